// File: doc/BRIEF.md
# Transmit Carrier and Heartbeat Monitor

This block sits beside a media-independent transmit path. It watches the carrier sense and collision inputs around each outgoing frame. During the frame it checks that carrier stays present once a short settling grace period has passed. After the frame it opens a fixed window in which the transceiver's heartbeat (signal quality test) pulse should show up on the collision line.

When the window closes, the block issues a two-bit status word with a one-cycle valid pulse. It also issues one-cycle increment strobes for two event counters: one for carrier loss and one for a missing heartbeat. Two independent configuration bits suppress the carrier check and the heartbeat check. Each bit removes both the status flag and the counter strobe for its event. Both bits must be set when the link runs full duplex.

Top module: `tx_link_watch`

## Requirements
- R1: After reset `sts_valid`, `inc_crs_lost` and `inc_sqe` are low and `sts_word` is 0; a reset applied while a heartbeat window is open discards that frame, so no status is issued for it.
- R2: A frame starts on the first clock where `tx_en` is sampled high after being low, and that clock is frame index 0. If `crs` is low on any clock with `tx_en` high at frame index `GRACE_CYC` (default 8) or later, bit 0 (carrier lost) of the frame's status word is 1.
- R3: `crs` low only on frame indices 0 to `GRACE_CYC`-1 leaves status bit 0 at 0.
- R4: With `cfg_crs_ignore` = 1, status bit 0 is 0 and `inc_crs_lost` stays low, whatever `crs` does.
- R5: The heartbeat window is the `HB_WIN` (default 64) clocks beginning with the first clock on which `tx_en` is sampled low after a frame. Status bit 1 (heartbeat missing) is 1 when `col` is low on every clock of the window and 0 when `col` is high on at least one of them, including the first and the last.
- R6: `col` high outside the window, either during the frame or on the clock after the window's last clock, does not count as a heartbeat.
- R7: With `cfg_hb_ignore` = 0, `sts_valid` is high for exactly one clock: the clock after the window's last clock. With `cfg_hb_ignore` = 1, it is high for one clock: the clock after the first low `tx_en` sample.
- R8: With `cfg_hb_ignore` = 1, status bit 1 is 0 and `inc_sqe` stays low.
- R9: `inc_crs_lost` and `inc_sqe` are one clock wide, each is high only together with `sts_valid`, and each equals the corresponding status bit (bit 0 and bit 1). This gives at most one strobe per frame per event.
- R10: `sts_word` keeps its value from one `sts_valid` pulse until the next one.
- R11: With both ignore bits set (full-duplex setting), the status word is 0 and neither strobe fires, even when `crs` drops mid-frame and no heartbeat arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| crs | input | 1 | Carrier sense from the transceiver |
| col | input | 1 | Collision / heartbeat from the transceiver |
| cfg_crs_ignore | input | 1 | 1 = do not monitor carrier sense |
| cfg_hb_ignore | input | 1 | 1 = do not check for the heartbeat |
| sts_word | output | 2 | Bit 0 carrier lost, bit 1 heartbeat missing; held between pulses |
| sts_valid | output | 1 | One-clock pulse when a new status word is issued |
| inc_crs_lost | output | 1 | Carrier-loss counter increment strobe |
| inc_sqe | output | 1 | Heartbeat-missing counter increment strobe |

## Verification
A wrong frame-index counter shows up as a wrong bit 0 when `crs` drops at index 7 or index 8. That error becomes visible at the status pulse, about 65 clocks after `tx_en` falls. A wrong window counter moves the `sts_valid` pulse away from its expected clock, or misjudges `col` on window clock 1, 64 or 65. Either fault can be seen on the first frame that hits it. A stale pending carrier flag, or stale heartbeat state carried across frames, corrupts the next frame's word. The alternating expected patterns in the vector table expose it.

// File: rtl/txw_pkg.sv
package txw_pkg;
    localparam int STS_W        = 2;
    localparam int STS_CRS_LOST = 0;
    localparam int STS_SQE      = 1;
endpackage

// File: rtl/txw_carrier.sv
module txw_carrier #(
    parameter int GRACE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic crs,
    input  logic ignore,
    output logic fall,
    output logic lost
);
    localparam int CW = $clog2(GRACE + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
        logic          lost;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tx_en;
        if (tx_en) begin
            if (!st_q.prev) begin
                st_d.cnt  = CW'(1);
                st_d.lost = 1'b0;
            end else if (st_q.cnt == CW'(GRACE)) begin
                if (!crs && !ignore) st_d.lost = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall = st_q.prev && !tx_en;
    assign lost = st_q.lost;

    p_grace_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(GRACE));
    p_lost_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> $past(tx_en) && !$past(crs));
endmodule

// File: rtl/txw_hb_window.sv
module txw_hb_window #(
    parameter int WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic col,
    input  logic ignore,
    output logic busy,
    output logic close,
    output logic missing
);
    localparam int WW = $clog2(WIN + 1);

    typedef struct packed {
        logic          active;
        logic [WW-1:0] cnt;
        logic          seen;
    } hst_t;

    hst_t st_d, st_q;
    logic seen_now;

    always_comb begin
        st_d     = st_q;
        close    = 1'b0;
        missing  = 1'b0;
        seen_now = st_q.seen || col;
        if (st_q.active) begin
            if (st_q.cnt == WW'(WIN - 1)) begin
                close       = 1'b1;
                missing     = !seen_now && !ignore;
                st_d.active = 1'b0;
            end else begin
                st_d.cnt  = st_q.cnt + WW'(1);
                st_d.seen = seen_now;
            end
        end else if (fall) begin
            if (ignore) begin
                close = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.cnt    = WW'(1);
                st_d.seen   = col;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.active;

    p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> st_q.cnt < WW'(WIN));
    p_win_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> $past(st_q.cnt) == WW'(WIN - 1));
endmodule

// File: rtl/tx_link_watch.sv
module tx_link_watch #(
    parameter int GRACE_CYC = 8,
    parameter int HB_WIN    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       crs,
    input  logic       col,
    input  logic       cfg_crs_ignore,
    input  logic       cfg_hb_ignore,
    output logic [1:0] sts_word,
    output logic       sts_valid,
    output logic       inc_crs_lost,
    output logic       inc_sqe
);
    import txw_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [STS_W-1:0] word;
        logic             inc_c;
        logic             inc_s;
        logic             pend;
    } tst_t;

    tst_t st_d, st_q;
    logic fall, lost, busy, close, missing, lost_rep;

    txw_carrier #(.GRACE(GRACE_CYC)) i_carrier (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .crs(crs),
        .ignore(cfg_crs_ignore), .fall(fall), .lost(lost)
    );

    txw_hb_window #(.WIN(HB_WIN)) i_window (
        .clk(clk), .rst_n(rst_n), .fall(fall), .col(col),
        .ignore(cfg_hb_ignore), .busy(busy), .close(close), .missing(missing)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = close;
        st_d.inc_c = 1'b0;
        st_d.inc_s = 1'b0;
        lost_rep   = (fall && !busy) ? lost : st_q.pend;
        if (fall && !busy) st_d.pend = lost;
        if (close) begin
            st_d.word[STS_CRS_LOST] = lost_rep && !cfg_crs_ignore;
            st_d.word[STS_SQE]      = missing;
            st_d.inc_c              = lost_rep && !cfg_crs_ignore;
            st_d.inc_s              = missing;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_word     = st_q.word;
    assign sts_valid    = st_q.valid;
    assign inc_crs_lost = st_q.inc_c;
    assign inc_sqe      = st_q.inc_s;

    p_crs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_crs_lost |-> sts_valid && sts_word[STS_CRS_LOST]);
    p_sqe_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_sqe |-> sts_valid && sts_word[STS_SQE]);
    p_crs_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid && $past(cfg_crs_ignore) |-> !sts_word[STS_CRS_LOST]);
    p_sqe_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid && $past(cfg_hb_ignore) |-> !sts_word[STS_SQE]);
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_valid |-> $stable(sts_word));
endmodule

// File: tb/test_tx_link_watch.sv
module test_tx_link_watch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, crs = 1'b1, col = 1'b0;
    logic cfg_crs_ignore = 1'b0, cfg_hb_ignore = 1'b0;
    logic [1:0] sts_word;
    logic sts_valid, inc_crs_lost, inc_sqe;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tx_link_watch i_tx_link_watch (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .crs(crs), .col(col),
        .cfg_crs_ignore(cfg_crs_ignore), .cfg_hb_ignore(cfg_hb_ignore),
        .sts_word(sts_word), .sts_valid(sts_valid),
        .inc_crs_lost(inc_crs_lost), .inc_sqe(inc_sqe)
    );

    // len, crs-low index (-1 none), col window clock (0 none, -1 last frame clock), crs_ign, hb_ign, expected word
    localparam int NV = 15;
    localparam int V_LEN [NV] = '{20, 20, 20, 20, 20, 20, 20, 20, 20, 20, 20, 20, 20, 9, 8};
    localparam int V_CRS [NV] = '{-1, 10, 7, 8, 0, -1, -1, -1, -1, -1, 12, 12, 12, 8, 7};
    localparam int V_COL [NV] = '{5, 5, 5, 5, 5, 0, 64, 1, 65, -1, 0, 0, 0, 0, 3};
    localparam int V_CI  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0};
    localparam int V_HI  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_EXP [NV] = '{0, 1, 0, 1, 0, 2, 0, 0, 2, 2, 2, 1, 0, 3, 0};
    localparam string V_REQ [NV] = '{"R5", "R2", "R3", "R2", "R3", "R5", "R5", "R5",
                                     "R6", "R6", "R4", "R8", "R11", "R2", "R3"};

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input int len, input int crs_low, input int col_at,
                             input int ci, input int hi, input int exp, input string req);
        int vstep = -1, pulses = 0, strobes_c = 0, strobes_s = 0;
        int word_at = -1, c_at = -1, s_at = -1;
        cfg_crs_ignore = ci[0];
        cfg_hb_ignore = hi[0];
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_en = 1'b1;
            crs = (i == crs_low) ? 1'b0 : 1'b1;
            col = (col_at == -1 && i == len - 1);
        end
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            if (k > 1) begin
                if (sts_valid) begin
                    pulses++; vstep = k; word_at = int'(sts_word);
                    c_at = int'(inc_crs_lost); s_at = int'(inc_sqe);
                end
                if (inc_crs_lost) strobes_c++;
                if (inc_sqe) strobes_s++;
            end
            tx_en = 1'b0;
            crs = 1'b1;
            col = (k == col_at);
        end
        check(req, "status word", word_at, exp);
        check("R7", "valid clock", vstep, (hi != 0) ? 2 : 65);
        check("R7", "valid pulse count", pulses, 1);
        check("R9", "carrier strobe at valid", c_at, exp & 1);
        check("R9", "sqe strobe at valid", s_at, (exp >> 1) & 1);
        check("R9", "carrier strobe count", strobes_c, exp & 1);
        check("R9", "sqe strobe count", strobes_s, (exp >> 1) & 1);
        check("R10", "word held", int'(sts_word), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset valid", int'(sts_valid), 0);
        check("R1", "reset word", int'(sts_word), 0);
        check("R1", "reset strobes", int'(inc_crs_lost) + int'(inc_sqe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++)
            run_frame(V_LEN[v], V_CRS[v], V_COL[v], V_CI[v], V_HI[v], V_EXP[v], V_REQ[v]);

        // R1: reset during an open window drops the frame
        begin
            int pulses = 0;
            cfg_crs_ignore = 1'b0; cfg_hb_ignore = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); tx_en = 1'b1; crs = (i == 15) ? 1'b0 : 1'b1;
            end
            @(negedge clk); tx_en = 1'b0; crs = 1'b1;
            repeat (10) @(negedge clk);
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (sts_valid) pulses++;
            end
            check("R1", "no status after mid-window reset", pulses, 0);
            check("R1", "word cleared by reset", int'(sts_word), 0);
        end

        // R11: full-duplex setting, carrier drop and no heartbeat
        run_frame(30, 20, 0, 1, 1, 0, "R11");
        // back-to-back frame after a carrier loss must report clean (R2 frame restart)
        run_frame(12, 10, 0, 0, 0, 3, "R2");
        run_frame(12, -1, 30, 0, 0, 0, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule